// File: doc/BRIEF.md
# System Flag Intercept Trap Generator

This block sits beside the retirement stage of a core that runs a legacy 32-bit instruction stream. Each retiring instruction that can touch the system flags or the stack segment is presented for one cycle. The block decides whether a system-flag intercept notification trap must follow that instruction. If so, it builds the trap record that the interruption logic will deliver.

There are four instruction classes: clear-interrupt, set-interrupt, pop-flags and stack-segment load. For the three flag-writing classes, the decision depends on three things: which of three watched flag bits changed, an enable that applies only to the interrupt flag, and a permission bit that says whether the code could modify the flags at all. A stack-segment load always traps.

The trap record holds:
- the vector number;
- a 16-bit code that names the instruction class and any concurrent single-step or debug condition;
- the previous flag word, zero-extended to 64 bits;
- the address of the trapping instruction and of the next instruction, each zero-extended to 64 bits.

The retirement input is a valid-only stream. The block accepts a presentation in every cycle, has no ready signal and never applies back-pressure. The record is registered. It appears one clock after the accepted presentation, together with a one-cycle `trap_valid` pulse, and is held until the next trap or reset. The consumer must take the record in the pulse cycle or before the next trap overwrites it.

Top module: `sfi_trap_gen`

## Requirements
- R1: For classes clear-interrupt (00), set-interrupt (01) and pop-flags (10), a trap is raised when the interrupt flag (bit 9) differs between `flags_old` and `flags_new` and `if_intercept_en` is 1.
- R2: For those three classes, a change in the trace flag (bit 8) or the alignment-check flag (bit 18) raises a trap whatever `if_intercept_en` holds. A change confined to other bits raises none. An interrupt-flag change with `if_intercept_en` at 0 raises none.
- R3: For those three classes, when `flag_perm` is 0 no trap is raised, whatever changed.
- R4: Class stack-segment load (11) always raises a trap, whatever the flags, `if_intercept_en` and `flag_perm` hold.
- R5: `trap_valid` is high for exactly the one cycle after a cycle with `retire_valid` high and a trap condition. It is never high after a cycle without `retire_valid`.
- R6: On a trap, `trap_imm[31:0]` holds the `flags_old` presented with the trapping instruction, and `trap_imm[63:32]` is zero.
- R7: On a trap, `trap_vector` is 2. `trap_code[15:14]` carries the class encoding (00, 01, 10, 11 as above), and `trap_code[13:8]` is zero.
- R8: `trap_code[0]` reports `step_hit`, `trap_code[1]` reports `debug_hit`, and `trap_code[7:2]` is zero.
- R9: On a trap, `trap_iip` is `next_addr` zero-extended to 64 bits, and `trap_iipa` is `insn_addr` zero-extended to 64 bits.
- R10: A presentation that raises no trap leaves every record output unchanged.
- R11: Synchronous reset clears `trap_valid` and every record output to zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| retire_valid | input | 1 | One retiring instruction is presented this cycle |
| inst_class | input | 2 | 00 clear-interrupt, 01 set-interrupt, 10 pop-flags, 11 stack-segment load |
| flags_old | input | 32 | Flag word before the instruction |
| flags_new | input | 32 | Flag word after the instruction |
| if_intercept_en | input | 1 | Enables trapping on interrupt-flag changes |
| flag_perm | input | 1 | Code had permission to modify the flags |
| insn_addr | input | 32 | Address of the retiring instruction |
| next_addr | input | 32 | Address of the following instruction |
| step_hit | input | 1 | Concurrent single-step condition |
| debug_hit | input | 1 | Concurrent debug condition |
| trap_valid | output | 1 | One-cycle trap pulse |
| trap_vector | output | 8 | Vector number |
| trap_code | output | 16 | Class identifier and concurrent trap code |
| trap_imm | output | 64 | Previous flag word, zero-extended |
| trap_iip | output | 64 | Next instruction address, zero-extended |
| trap_iipa | output | 64 | Trapping instruction address, zero-extended |

## Verification
Directed cases change one watched bit at a time under each class, with the enable both on and off:
- the interrupt flag with the enable on and with it off tells the enable gating apart from the trace and alignment rules;
- changes confined to unwatched bits show that only the three watched positions matter;
- the permission bit held low, with a watched change, separates the privilege veto from the stack-segment load, which must trap regardless;
- presentations with a trap condition but `retire_valid` low show that the strobe alone starts a trap.

Random traffic sets the three watched bits' change pattern, the class, the enable, the permission and the concurrent-condition inputs independently. It also uses addresses with the top bit set, so that zero extension and record hold-over between traps are compared every cycle.

// File: rtl/sfi_pkg.sv
package sfi_pkg;
  localparam int FLAG_W = 32;
  localparam int ADDR_W = 32;
  localparam int REG_W  = 64;
  localparam int VEC_W  = 8;
  localparam int CODE_W = 16;

  localparam int IF_POS = 9;
  localparam int TF_POS = 8;
  localparam int AC_POS = 18;

  localparam logic [VEC_W-1:0] TRAP_VECTOR = 8'd2;

  typedef enum logic [1:0] {
    CLS_CLRINT = 2'b00,
    CLS_SETINT = 2'b01,
    CLS_POPFL  = 2'b10,
    CLS_SSLOAD = 2'b11
  } inst_class_e;

  typedef struct packed {
    logic [VEC_W-1:0]  vector;
    logic [CODE_W-1:0] code;
    logic [REG_W-1:0]  imm;
    logic [REG_W-1:0]  iip;
    logic [REG_W-1:0]  iipa;
  } trap_rec_t;
endpackage

// File: rtl/sfi_flag_watch.sv
module sfi_flag_watch
  import sfi_pkg::*;
#(
  parameter int W      = FLAG_W,
  parameter int IF_BIT = IF_POS,
  parameter int TF_BIT = TF_POS,
  parameter int AC_BIT = AC_POS
) (
  input  logic [1:0]   cls,
  input  logic [W-1:0] f_old,
  input  logic [W-1:0] f_new,
  input  logic         if_en,
  input  logic         perm,
  output logic         trap_req
);
  localparam int NW = 3;
  localparam int POS [NW] = '{IF_BIT, TF_BIT, AC_BIT};

  logic [NW-1:0] changed;
  logic [NW-1:0] gate;

  // one comparator per watched bit; only the interrupt flag is gated
  for (genvar g = 0; g < NW; g++) begin : g_watch
    assign changed[g] = f_old[POS[g]] ^ f_new[POS[g]];
    if (g == 0) begin : g_gated
      assign gate[g] = changed[g] & if_en;
    end else begin : g_free
      assign gate[g] = changed[g];
    end
  end

  always_comb begin
    if (inst_class_e'(cls) == CLS_SSLOAD) trap_req = 1'b1;
    else                                  trap_req = perm & (|gate);
  end
endmodule

// File: rtl/sfi_zext.sv
module sfi_zext #(
  parameter int IN_W  = 32,
  parameter int OUT_W = 64
) (
  input  logic [IN_W-1:0]  din,
  output logic [OUT_W-1:0] dout
);
  localparam int PAD = OUT_W - IN_W;
  if (PAD > 0) begin : g_pad
    assign dout = {{PAD{1'b0}}, din};
  end else begin : g_nopad
    assign dout = din[OUT_W-1:0];
  end
endmodule

// File: rtl/sfi_code_pack.sv
module sfi_code_pack
  import sfi_pkg::*;
#(
  parameter int CW = CODE_W
) (
  input  logic [1:0]    cls,
  input  logic          step,
  input  logic          dbg,
  output logic [CW-1:0] code
);
  localparam int ID_LO = CW - 2;
  always_comb begin
    code = '0;
    code[CW-1:ID_LO] = cls;
    code[0] = step;
    code[1] = dbg;
  end
endmodule

// File: rtl/sfi_trap_gen.sv
module sfi_trap_gen
  import sfi_pkg::*;
#(
  parameter int FW = FLAG_W,
  parameter int AW = ADDR_W,
  parameter int RW = REG_W
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          retire_valid,
  input  logic [1:0]    inst_class,
  input  logic [FW-1:0] flags_old,
  input  logic [FW-1:0] flags_new,
  input  logic          if_intercept_en,
  input  logic          flag_perm,
  input  logic [AW-1:0] insn_addr,
  input  logic [AW-1:0] next_addr,
  input  logic          step_hit,
  input  logic          debug_hit,
  output logic          trap_valid,
  output logic [VEC_W-1:0]  trap_vector,
  output logic [CODE_W-1:0] trap_code,
  output logic [RW-1:0] trap_imm,
  output logic [RW-1:0] trap_iip,
  output logic [RW-1:0] trap_iipa
);
  logic      trap_req;
  logic      take;
  trap_rec_t nxt_rec;
  trap_rec_t rec_q;
  logic      valid_q;
  logic [CODE_W-1:0] code_w;
  logic [RW-1:0] imm_w, iip_w, iipa_w;

  sfi_flag_watch #(.W(FW)) u_watch (
    .cls(inst_class), .f_old(flags_old), .f_new(flags_new),
    .if_en(if_intercept_en), .perm(flag_perm), .trap_req(trap_req)
  );

  sfi_code_pack u_code (
    .cls(inst_class), .step(step_hit), .dbg(debug_hit), .code(code_w)
  );

  sfi_zext #(.IN_W(FW), .OUT_W(RW)) u_imm  (.din(flags_old), .dout(imm_w));
  sfi_zext #(.IN_W(AW), .OUT_W(RW)) u_iip  (.din(next_addr), .dout(iip_w));
  sfi_zext #(.IN_W(AW), .OUT_W(RW)) u_iipa (.din(insn_addr), .dout(iipa_w));

  assign take = retire_valid & trap_req;

  always_comb begin
    nxt_rec.vector = TRAP_VECTOR;
    nxt_rec.code   = code_w;
    nxt_rec.imm    = imm_w;
    nxt_rec.iip    = iip_w;
    nxt_rec.iipa   = iipa_w;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      valid_q <= 1'b0;
      rec_q   <= '0;
    end else begin
      valid_q <= take;
      if (take) rec_q <= nxt_rec;
    end
  end

  assign trap_valid  = valid_q;
  assign trap_vector = rec_q.vector;
  assign trap_code   = rec_q.code;
  assign trap_imm    = rec_q.imm;
  assign trap_iip    = rec_q.iip;
  assign trap_iipa   = rec_q.iipa;
endmodule

// File: rtl/sfi_trap_chk.sv
module sfi_trap_chk (
  input logic        clk,
  input logic        rst,
  input logic        retire_valid,
  input logic [1:0]  inst_class,
  input logic [31:0] flags_old,
  input logic        flag_perm,
  input logic [31:0] next_addr,
  input logic [31:0] insn_addr,
  input logic        trap_valid,
  input logic [7:0]  trap_vector,
  input logic [15:0] trap_code,
  input logic [63:0] trap_imm,
  input logic [63:0] trap_iip,
  input logic [63:0] trap_iipa
);
  assert_ss_traps_R4: assert property (@(posedge clk) disable iff (rst)
    (retire_valid && inst_class == 2'b11) |=> trap_valid);

  assert_no_perm_R3: assert property (@(posedge clk) disable iff (rst)
    (retire_valid && inst_class != 2'b11 && !flag_perm) |=> !trap_valid);

  assert_needs_strobe_R5: assert property (@(posedge clk) disable iff (rst)
    !retire_valid |=> !trap_valid);

  assert_old_flags_R6: assert property (@(posedge clk) disable iff (rst)
    (retire_valid && inst_class == 2'b11) |=> trap_imm == {32'd0, $past(flags_old)});

  assert_vector_id_R7: assert property (@(posedge clk) disable iff (rst)
    (retire_valid && inst_class == 2'b11) |=> (trap_vector == 8'd2 && trap_code[15:14] == 2'b11));

  assert_addrs_R9: assert property (@(posedge clk) disable iff (rst)
    (retire_valid && inst_class == 2'b11) |=>
      (trap_iip == {32'd0, $past(next_addr)} && trap_iipa == {32'd0, $past(insn_addr)}));

  assert_hold_R10: assert property (@(posedge clk) disable iff (rst)
    !retire_valid |=> ($stable(trap_imm) && $stable(trap_code) && $stable(trap_iip)));
endmodule

bind sfi_trap_gen sfi_trap_chk u_chk (
  .clk(clk), .rst(rst), .retire_valid(retire_valid), .inst_class(inst_class),
  .flags_old(flags_old), .flag_perm(flag_perm), .next_addr(next_addr),
  .insn_addr(insn_addr), .trap_valid(trap_valid), .trap_vector(trap_vector),
  .trap_code(trap_code), .trap_imm(trap_imm), .trap_iip(trap_iip),
  .trap_iipa(trap_iipa)
);

// File: tb/test_sfi_trap_gen.sv
module test_sfi_trap_gen;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic retire_valid = 1'b0;
  logic [1:0]  inst_class = '0;
  logic [31:0] flags_old = '0, flags_new = '0;
  logic if_intercept_en = 1'b0, flag_perm = 1'b0;
  logic [31:0] insn_addr = '0, next_addr = '0;
  logic step_hit = 1'b0, debug_hit = 1'b0;
  logic trap_valid;
  logic [7:0]  trap_vector;
  logic [15:0] trap_code;
  logic [63:0] trap_imm, trap_iip, trap_iipa;

  int errors = 0;
  int checks = 0;

  logic        m_valid;
  logic [15:0] m_code;
  logic [7:0]  m_vec;
  logic [63:0] m_imm, m_iip, m_iipa;

  always #5 clk = ~clk;

  sfi_trap_gen i_sfi_trap_gen (
    .clk(clk), .rst(rst), .retire_valid(retire_valid), .inst_class(inst_class),
    .flags_old(flags_old), .flags_new(flags_new), .if_intercept_en(if_intercept_en),
    .flag_perm(flag_perm), .insn_addr(insn_addr), .next_addr(next_addr),
    .step_hit(step_hit), .debug_hit(debug_hit), .trap_valid(trap_valid),
    .trap_vector(trap_vector), .trap_code(trap_code), .trap_imm(trap_imm),
    .trap_iip(trap_iip), .trap_iipa(trap_iipa)
  );

  function automatic logic want_trap(input logic [1:0] c, input logic [31:0] o,
                                     input logic [31:0] n, input logic en, input logic p);
    logic [31:0] d;
    d = o ^ n;
    if (c == 2'b11) return 1'b1;
    if (!p) return 1'b0;
    return (d[9] & en) | d[8] | d[18];
  endfunction

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic check_all(input string tag);
    chk({tag, " R5 valid"}, {63'd0, trap_valid}, {63'd0, m_valid});
    chk({tag, " R7 vector"}, {56'd0, trap_vector}, {56'd0, m_vec});
    chk({tag, " R7/R8 code"}, {48'd0, trap_code}, {48'd0, m_code});
    chk({tag, " R6 imm"}, trap_imm, m_imm);
    chk({tag, " R9 iip"}, trap_iip, m_iip);
    chk({tag, " R9 iipa"}, trap_iipa, m_iipa);
  endtask

  // drive at negedge, let one posedge pass, compare at the next negedge
  task automatic step(input logic v, input logic [1:0] c, input logic [31:0] o,
                      input logic [31:0] n, input logic en, input logic p,
                      input logic [31:0] ia, input logic [31:0] na,
                      input logic s, input logic d, input string tag);
    logic t;
    retire_valid = v; inst_class = c; flags_old = o; flags_new = n;
    if_intercept_en = en; flag_perm = p; insn_addr = ia; next_addr = na;
    step_hit = s; debug_hit = d;
    @(posedge clk);
    t = v & want_trap(c, o, n, en, p);
    if (rst) begin
      m_valid = 0; m_vec = 0; m_code = 0; m_imm = 0; m_iip = 0; m_iipa = 0;
    end else begin
      m_valid = t;
      if (t) begin
        m_vec = 8'd2;
        m_code = {c, 6'd0, 6'd0, d, s};
        m_imm = {32'd0, o};
        m_iip = {32'd0, na};
        m_iipa = {32'd0, ia};
      end
    end
    @(negedge clk);
    check_all(tag);
  endtask

  initial begin
    #1_000_000;
    errors++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", errors, checks + 1);
    $finish;
  end

  initial begin
    void'($urandom(32'h5f1c_0042));
    m_valid = 0; m_vec = 0; m_code = 0; m_imm = 0; m_iip = 0; m_iipa = 0;
    @(negedge clk);
    step(1, 2'b11, 32'h1, 32'h2, 1, 1, 32'h10, 32'h11, 1, 1, "R11 during reset");
    rst = 1'b0;
    check_all("R11 reset state");

    // R1: interrupt flag change with enable on, each flag class
    step(1, 2'b00, 32'h200, 32'h0,   1, 1, 32'h1000, 32'h1001, 0, 0, "R1 clr");
    step(1, 2'b01, 32'h0,   32'h200, 1, 1, 32'h1001, 32'h1002, 0, 0, "R1 set");
    step(1, 2'b10, 32'h200, 32'h0,   1, 1, 32'h1002, 32'h1003, 0, 0, "R1 pop");
    // R2: enable off hides interrupt-flag change; trace/align still trap
    step(1, 2'b01, 32'h0, 32'h200, 0, 1, 32'h2000, 32'h2001, 0, 0, "R2 if gated");
    step(1, 2'b10, 32'h0, 32'h100, 0, 1, 32'h2001, 32'h2003, 0, 0, "R2 trace");
    step(1, 2'b10, 32'h40000, 32'h0, 0, 1, 32'h2003, 32'h2004, 0, 0, "R2 align");
    step(1, 2'b10, 32'h0, 32'hFFFB_FCFF, 1, 1, 32'h2004, 32'h2005, 0, 0, "R2 R10 other bits");
    // R3: permission veto
    step(1, 2'b10, 32'h0, 32'h40300, 1, 0, 32'h3000, 32'h3001, 0, 0, "R3 no perm");
    // R4: stack-segment load, no change, no perm
    step(1, 2'b11, 32'h5, 32'h5, 0, 0, 32'hFFFF_FFF0, 32'hFFFF_FFF3, 0, 0, "R4 R9 ss");
    // R5: condition without strobe; R10 hold
    step(0, 2'b11, 32'h7, 32'h7, 1, 1, 32'h4000, 32'h4001, 1, 1, "R5 R10 no strobe");
    // R8: concurrent conditions
    step(1, 2'b00, 32'h100, 32'h0, 0, 1, 32'h5000, 32'h5001, 1, 0, "R8 step");
    step(1, 2'b11, 32'h0, 32'h0, 0, 1, 32'h5001, 32'h5002, 0, 1, "R8 debug");
    step(1, 2'b01, 32'hFFFF_FFFF, 32'hFFFF_FDFF, 1, 1, 32'h8000_0000, 32'h8000_0001, 1, 1, "R6 R8 both");

    for (int i = 0; i < 400; i++) begin
      logic [31:0] o, mask;
      logic [31:0] r;
      o = $urandom();
      r = $urandom();
      mask = $urandom() & 32'hFFFB_FCFF & {32{r[4]}};
      if (r[0] && r[1]) mask[9] = 1'b1;
      if (r[2] && r[3]) mask[8] = 1'b1;
      if (r[5] && r[6]) mask[18] = 1'b1;
      step(r[7] | r[8], r[10:9], o, o ^ mask, r[11], r[12] | r[13],
           $urandom(), $urandom(), r[14], r[15], "R1 R2 R3 R4 R10 random");
    end

    rst = 1'b1;
    step(1, 2'b11, 32'h3, 32'h3, 1, 1, 32'h9, 32'ha, 1, 1, "R11 reset again");
    rst = 1'b0;
    step(0, 2'b00, 32'h0, 32'h0, 0, 0, 32'h0, 32'h0, 0, 0, "R11 after reset");

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule